// File: doc/BRIEF.md
# CAN Bus Wake-Up Pulse Detector

This block listens to the level from a low-power bus receiver while the transceiver sleeps. It decides whether the bus traffic is a real wake request. A dominant pulse counts only when its width lies strictly inside a window. Successive counted pulses must also follow each other closely enough. After the required number of counted pulses, a sticky wake flag is raised for the power controller.

The raw receiver level first passes through a synchronizer. A width meter then times each dominant interval and marks it as accepted or discarded. A qualifier keeps a count of accepted pulses and runs a spacing timer. It sets the flag on the last required pulse. All time limits are parameters counted in clock cycles.

The flag is cleared when the transceiver is switched to normal operation, which ends the wake cycle. A control input turns detection off altogether.

Top module: `can_wake_detect`

## Requirements
- R1: `rx_level` is 1 for recessive and 0 for dominant. It is sampled through SYNC_STAGES (default two) flip-flops. A dominant pulse of N clock cycles is accepted when MIN_W < N < MAX_W.
- R2: A dominant pulse with N <= MIN_W, or with N >= MAX_W, is discarded. Discarding sets the accepted-pulse count to zero and does not raise `wake_flag`. A pulse that is still dominant at its MAX_W-th cycle is discarded at once. Nothing more is timed until the line has returned to recessive.
- R3: Each accepted pulse adds one to the count. `wake_flag` goes to 1 within 5 clock cycles after the recessive return of the NEED_PULSES-th (default 3) accepted pulse. A count that has not reached NEED_PULSES leaves `wake_flag` at 0.
- R4: After an accepted pulse, a recessive gap of at most GAP_MAX cycles before the next dominant pulse keeps the count. A gap of more than GAP_MAX cycles sets the count to zero.
- R5: Once set, `wake_flag` stays at 1 whatever the line does, until `normal_mode` is 1. A cycle with `normal_mode` at 1 clears `wake_flag` in the next cycle. It also clears the count and the spacing timer.
- R6: While `det_en` is 0, `wake_flag` is never set and pulses are not counted. Driving `det_en` to 0 also clears the count.
- R7: A synchronous active-high `rst` clears all state, including `wake_flag`. After reset, `wake_flag` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 1 | Raw level from the low-power receiver, 0 = dominant |
| det_en | input | 1 | 1 enables wake detection |
| normal_mode | input | 1 | 1 while the transceiver is in normal mode; clears the wake cycle |
| wake_flag | output | 1 | Sticky wake indication, registered |

## Verification
Several properties are checked on every cycle by the assertions:
- the flag stays set until normal mode, and normal mode clears it in the next cycle;
- the flag never rises while detection is disabled, and rises only right after an accepted pulse;
- a discarded pulse empties the count, and the count grows only on an accepted pulse and never reaches the target.

Other behaviour can only be shown by the bench scenarios. These cover the exact width limits, the exact spacing limit, discarding an over-long pulse while the line is still dominant, and the count restarting after a disable or a normal-mode cycle.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_MEAS = 2'd1,
    MS_HOLD = 2'd2
  } meas_state_t;
endpackage

// File: rtl/cwd_sync.sv
module cwd_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= RESET_VAL;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/cwd_width_meter.sv
module cwd_width_meter
  import cwd_pkg::*;
#(
  parameter int MIN_W = 8,
  parameter int MAX_W = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic line_s,
  output logic pstart,
  output logic acc,
  output logic rej
);
  localparam int CW = $clog2(MAX_W + 1);
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_W);
  localparam logic [CW-1:0] LAST_C = CW'(MAX_W - 1);

  meas_state_t    st;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= MS_IDLE;
      cnt    <= '0;
      pstart <= 1'b0;
      acc    <= 1'b0;
      rej    <= 1'b0;
    end else begin
      pstart <= 1'b0;
      acc    <= 1'b0;
      rej    <= 1'b0;
      if (clr) begin
        st  <= line_s ? MS_IDLE : MS_HOLD;
        cnt <= '0;
      end else begin
        case (st)
          MS_IDLE: begin
            if (!line_s) begin
              st     <= MS_MEAS;
              cnt    <= CW'(1);
              pstart <= 1'b1;
            end
          end
          MS_MEAS: begin
            if (line_s) begin
              st <= MS_IDLE;
              if (cnt > MIN_C) acc <= 1'b1;
              else             rej <= 1'b1;
            end else if (cnt == LAST_C) begin
              st  <= MS_HOLD;
              rej <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          MS_HOLD: begin
            if (line_s) st <= MS_IDLE;
          end
          default: st <= MS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cwd_qualifier.sv
module cwd_qualifier #(
  parameter int NEED_PULSES = 3,
  parameter int GAP_MAX     = 8000,
  localparam int PW = (NEED_PULSES > 1) ? $clog2(NEED_PULSES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          norm,
  input  logic          pstart,
  input  logic          acc,
  input  logic          rej,
  output logic          wake,
  output logic [PW-1:0] pcount
);
  localparam int GW = $clog2(GAP_MAX + 1);
  localparam logic [PW-1:0] TOP_C = PW'(NEED_PULSES - 1);
  localparam logic [GW-1:0] GAP_C = GW'(GAP_MAX - 1);

  logic [GW-1:0] gtmr;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake <= 1'b0;
    end else if (norm) begin
      wake <= 1'b0;
    end else if (en && acc && pcount == TOP_C) begin
      wake <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || norm) begin
      pcount <= '0;
      armed  <= 1'b0;
      gtmr   <= '0;
    end else if (rej) begin
      pcount <= '0;
      armed  <= 1'b0;
    end else if (acc) begin
      gtmr <= '0;
      if (pcount == TOP_C) begin
        pcount <= '0;
        armed  <= 1'b0;
      end else begin
        pcount <= pcount + PW'(1);
        armed  <= 1'b1;
      end
    end else if (pstart) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (gtmr == GAP_C) begin
        pcount <= '0;
        armed  <= 1'b0;
        gtmr   <= '0;
      end else begin
        gtmr <= gtmr + GW'(1);
      end
    end
  end
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect #(
  parameter int MIN_W       = 8,
  parameter int MAX_W       = 8000,
  parameter int GAP_MAX     = 8000,
  parameter int NEED_PULSES = 3,
  parameter int SYNC_STAGES = 2,
  localparam int PW = (NEED_PULSES > 1) ? $clog2(NEED_PULSES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_level,
  input  logic det_en,
  input  logic normal_mode,
  output logic wake_flag
);
  logic          line_s;
  logic          hold_off;
  logic          pstart;
  logic          acc_pulse;
  logic          rej_pulse;
  logic [PW-1:0] pcount;

  assign hold_off = !det_en || normal_mode;

  cwd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rx_level),
    .d_out (line_s)
  );

  cwd_width_meter #(.MIN_W(MIN_W), .MAX_W(MAX_W)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .clr    (hold_off),
    .line_s (line_s),
    .pstart (pstart),
    .acc    (acc_pulse),
    .rej    (rej_pulse)
  );

  cwd_qualifier #(.NEED_PULSES(NEED_PULSES), .GAP_MAX(GAP_MAX)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .en     (det_en),
    .norm   (normal_mode),
    .pstart (pstart),
    .acc    (acc_pulse),
    .rej    (rej_pulse),
    .wake   (wake_flag),
    .pcount (pcount)
  );
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int NEED_PULSES = 3,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          det_en,
  input logic          normal_mode,
  input logic          wake_flag,
  input logic          acc_pulse,
  input logic          rej_pulse,
  input logic [PW-1:0] pcount
);
  assert_clear_on_normal_R5: assert property (@(posedge clk) disable iff (rst)
    normal_mode |=> !wake_flag);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (wake_flag && !normal_mode) |=> wake_flag);

  assert_no_set_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (!det_en && !wake_flag) |=> !wake_flag);

  assert_rise_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> $past(acc_pulse));

  assert_discard_empties_R2: assert property (@(posedge clk) disable iff (rst)
    rej_pulse |=> (pcount == '0));

  assert_count_grows_on_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (pcount > $past(pcount)) |-> $past(acc_pulse));

  assert_count_below_target_R3: assert property (@(posedge clk) disable iff (rst)
    int'(pcount) < NEED_PULSES);

  assert_single_verdict_R2: assert property (@(posedge clk) disable iff (rst)
    !(acc_pulse && rej_pulse));
endmodule

bind can_wake_detect cwd_checker #(.NEED_PULSES(NEED_PULSES), .PW(PW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .det_en      (det_en),
  .normal_mode (normal_mode),
  .wake_flag   (wake_flag),
  .acc_pulse   (acc_pulse),
  .rej_pulse   (rej_pulse),
  .pcount      (pcount)
);

// File: tb/test_can_wake_detect.sv
module test_can_wake_detect;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int MIN_W = 4;
  localparam int MAX_W = 40;
  localparam int GAP   = 60;
  localparam int NEED  = 3;

  typedef struct {
    logic  exp;
    string tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_level = 1'b1;
  logic det_en = 1'b1;
  logic normal_mode = 1'b0;
  logic wake_flag;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  can_wake_detect #(
    .MIN_W(MIN_W), .MAX_W(MAX_W), .GAP_MAX(GAP), .NEED_PULSES(NEED), .SYNC_STAGES(2)
  ) i_can_wake_detect (
    .clk(clk), .rst(rst), .rx_level(rx_level), .det_en(det_en),
    .normal_mode(normal_mode), .wake_flag(wake_flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w);
    rx_level = 1'b0;
    step(w);
    rx_level = 1'b1;
  endtask

  task automatic trio(input int w, input int g);
    pulse(w); step(g);
    pulse(w); step(g);
    pulse(w); step(8);
  endtask

  task automatic expect_flag(input logic e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    step(1);
  endtask

  task automatic clear_cycle();
    normal_mode = 1'b1;
    step(2);
    normal_mode = 1'b0;
    step(GAP + 10);
  endtask

  initial begin : monitor
    sb_item_t it;
    forever begin
      wait (sb_q.size() != 0);
      @(negedge clk);
      it = sb_q[0];
      n_vec++;
      if (wake_flag !== it.exp) begin
        n_bad++;
        $display("FAIL %s: wake_flag actual %b expected %b", it.tag, wake_flag, it.exp);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all requirements: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    rst = 1'b0;
    step(2);
    expect_flag(1'b0, "R7 reset state");

    trio(10, 20);
    expect_flag(1'b1, "R3 three accepted pulses");
    step(200);
    pulse(100); step(10);
    expect_flag(1'b1, "R5 flag sticky");
    normal_mode = 1'b1; step(1); normal_mode = 1'b0; step(1);
    expect_flag(1'b0, "R5 normal mode clears");
    step(GAP + 10);

    trio(MIN_W + 1, 15);
    expect_flag(1'b1, "R1 width MIN_W+1 accepted");
    clear_cycle();
    trio(MAX_W - 1, 15);
    expect_flag(1'b1, "R1 width MAX_W-1 accepted");
    clear_cycle();

    pulse(10); step(10); pulse(10); step(10); pulse(MIN_W); step(10);
    pulse(10); step(10); pulse(10); step(8);
    expect_flag(1'b0, "R2 width MIN_W discards count");
    pulse(10); step(8);
    expect_flag(1'b1, "R2 count restarts after short pulse");
    clear_cycle();

    pulse(10); step(10); pulse(10); step(10); pulse(MAX_W); step(10);
    pulse(10); step(10); pulse(10); step(8);
    expect_flag(1'b0, "R2 width MAX_W discards count");
    pulse(10); step(8);
    expect_flag(1'b1, "R2 count restarts after long pulse");
    clear_cycle();

    pulse(10); step(10); pulse(10); step(10); pulse(150); step(10);
    pulse(10); step(10); pulse(10); step(8);
    expect_flag(1'b0, "R2 overlong pulse discarded");
    clear_cycle();

    trio(10, GAP);
    expect_flag(1'b1, "R4 gap of GAP_MAX kept");
    clear_cycle();
    pulse(10); step(GAP + 1); pulse(10); step(GAP + 1); pulse(10); step(8);
    expect_flag(1'b0, "R4 gap of GAP_MAX+1 times out");
    pulse(10); step(10); pulse(10); step(8);
    expect_flag(1'b1, "R4 count resumes after time-out");
    clear_cycle();

    det_en = 1'b0;
    trio(10, 20);
    expect_flag(1'b0, "R6 disabled never sets");
    det_en = 1'b1;
    step(5);
    pulse(10); step(10); pulse(10); step(5);
    det_en = 1'b0; step(2); det_en = 1'b1; step(3);
    pulse(10); step(8);
    expect_flag(1'b0, "R6 disable clears count a");
    pulse(10); step(8);
    expect_flag(1'b0, "R6 disable clears count b");
    pulse(10); step(8);
    expect_flag(1'b1, "R6 enabled counting resumes");
    clear_cycle();

    pulse(10); step(10); pulse(10); step(5);
    normal_mode = 1'b1; step(2); normal_mode = 1'b0; step(3);
    pulse(10); step(10); pulse(10); step(8);
    expect_flag(1'b0, "R5 normal mode clears count");
    pulse(10); step(8);
    expect_flag(1'b1, "R5 third pulse after normal mode");

    rst = 1'b1; step(2); rst = 1'b0; step(2);
    expect_flag(1'b0, "R7 reset clears flag");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule